// File: doc/BRIEF.md
# Rotating Result Packer with DMA Request

Three converters take turns producing 16-bit results in a fixed rotation: A, then B, then C, then A again. This block takes each result from the source whose turn it is and places it in one half of a 32-bit output word. The first result of a pair goes into a holding register. The second result completes the pair, and the output word is loaded with the second result in the upper half and the held result in the lower half. Because the number of sources is odd, the pairing rotates. Successive words carry B|A, then A|C, then C|B, and the pattern then repeats.

When the two-bit transfer-mode input selects the packed mode (binary 10), each completed pair raises a DMA request. The request stays high until the DMA engine acknowledges it. If a newer pair completes before the request is acknowledged, the newer pair overwrites the word and a sticky overrun flag is set. In any other mode the word still updates but no request is raised. Any change of the mode input restarts the rotation at source A and the lower slot.

Top module: `rotating_packer`

## Requirements
- R1: Only the source whose turn it is can be accepted, in the rotation A, B, C, A, and so on. A valid strobe from any other source is ignored, and at most one result is taken per cycle.
- R2: The earlier result of a pair occupies bits 15:0 of the output word, and the later result occupies bits 31:16.
- R3: Starting from a restart, successive completed words are {B,A}, {A,C}, {C,B}, then {B,A} again, repeating.
- R4: The output word changes only on the clock edge at which the second result of a pair is taken. It holds its value at every other edge.
- R5: When a pair completes while the mode input is 2'b10, the request output is high from the following edge.
- R6: The request stays high until the acknowledge input is sampled high. The acknowledge clears it unless a new pair completes in the same cycle, in which case it stays high.
- R7: If a pair completes in mode 2'b10 while the request is high and not being acknowledged, the overrun flag is set and stays set until reset. The new pair replaces the word.
- R8: In any mode other than 2'b10, completed pairs still update the word but never raise the request.
- R9: After reset the word is zero, the request and the overrun flag are low, and the rotation expects source A in the lower slot.
- R10: In a cycle where the mode input differs from its value at the previous edge, no result is taken. Any half-finished pair is dropped, and the rotation restarts at source A in the lower slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dma_mode | input | 2 | Transfer mode; 2'b10 enables requests |
| a_valid | input | 1 | Source A result strobe |
| a_data | input | 16 | Source A result |
| b_valid | input | 1 | Source B result strobe |
| b_data | input | 16 | Source B result |
| c_valid | input | 1 | Source C result strobe |
| c_data | input | 16 | Source C result |
| dma_ack | input | 1 | Request acknowledge |
| pack_word | output | 32 | Packed result pair, later result on top |
| dma_req | output | 1 | Pending transfer request |
| overrun | output | 1 | Sticky flag for a pair lost before acknowledge |

## Verification
Two events can fall in the same cycle: the completion of a new pair and the acknowledge of the pending request. The bench provokes this in two ways. It drives the second result of a pair together with the acknowledge, and it drives the second result of a pair with no acknowledge while a request is still pending. In the first case the request must stay high with no overrun. In the second case the overrun flag must rise and the word must be replaced. A behavioural reference model, updated on every edge, judges both cases against the outputs. A long pseudo-random run of strobes and acknowledges then makes both collisions happen many more times.

// File: rtl/rpk_pkg.sv
package rpk_pkg;
  localparam int RPK_DATA_W = 16;
  localparam int RPK_NSRC   = 3;
  localparam int RPK_SRC_W  = 2;

  localparam logic [RPK_SRC_W-1:0] SRC_A = 2'd0;
  localparam logic [RPK_SRC_W-1:0] SRC_B = 2'd1;
  localparam logic [RPK_SRC_W-1:0] SRC_C = 2'd2;

  // next source in the round-robin turn order
  function automatic logic [RPK_SRC_W-1:0] next_src(input logic [RPK_SRC_W-1:0] s);
    next_src = (s == SRC_C) ? SRC_A : s + 1'b1;
  endfunction

  // later half on top, earlier half at the bottom
  function automatic logic [2*RPK_DATA_W-1:0] join_pair(input logic [RPK_DATA_W-1:0] later,
                                                        input logic [RPK_DATA_W-1:0] earlier);
    join_pair = {later, earlier};
  endfunction
endpackage

// File: rtl/rpk_src_sel.sv
module rpk_src_sel
  import rpk_pkg::*;
#(
  parameter int DATA_W = RPK_DATA_W,
  parameter int NSRC   = RPK_NSRC
) (
  input  logic [NSRC-1:0]             vld,
  input  logic [NSRC-1:0][DATA_W-1:0] dat,
  input  logic [RPK_SRC_W-1:0]        cur_src,
  input  logic                        enable,
  output logic [NSRC-1:0]             take_vec,
  output logic                        take,
  output logic [DATA_W-1:0]           take_data
);
  for (genvar i = 0; i < NSRC; i++) begin : g_hit
    assign take_vec[i] = enable && vld[i] && (cur_src == RPK_SRC_W'(i));
  end

  assign take = |take_vec;

  always_comb begin
    take_data = '0;
    for (int i = 0; i < NSRC; i++) begin
      if (take_vec[i]) take_data = take_data | dat[i];
    end
  end
endmodule

// File: rtl/rpk_pair_builder.sv
module rpk_pair_builder
  import rpk_pkg::*;
#(
  parameter int DATA_W = RPK_DATA_W,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 restart,
  input  logic                 take,
  input  logic [DATA_W-1:0]    take_data,
  output logic [RPK_SRC_W-1:0] src_q,
  output logic                 slot_q,
  output logic                 pair_done,
  output logic [WORD_W-1:0]    word_q
);
  logic [DATA_W-1:0] low_q;

  assign pair_done = take && slot_q && !restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_A;
      slot_q <= 1'b0;
      low_q  <= '0;
      word_q <= '0;
    end else if (restart) begin
      src_q  <= SRC_A;
      slot_q <= 1'b0;
    end else if (take) begin
      src_q <= next_src(src_q);
      if (!slot_q) begin
        low_q  <= take_data;
        slot_q <= 1'b1;
      end else begin
        word_q <= join_pair(take_data, low_q);
        slot_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/rpk_req_ctrl.sv
module rpk_req_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic pair_done,
  input  logic req_en,
  input  logic ack,
  output logic req,
  output logic ovr
);
  logic raise;
  logic lost;

  assign raise = pair_done && req_en;
  assign lost  = raise && req && !ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req <= 1'b0;
      ovr <= 1'b0;
    end else begin
      if (raise)    req <= 1'b1;
      else if (ack) req <= 1'b0;
      if (lost)     ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/rotating_packer.sv
module rotating_packer
  import rpk_pkg::*;
#(
  parameter int DATA_W = RPK_DATA_W,
  parameter int MODE_W = 2,
  parameter logic [MODE_W-1:0] REQ_MODE = 2'b10,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] dma_mode,
  input  logic              a_valid,
  input  logic [DATA_W-1:0] a_data,
  input  logic              b_valid,
  input  logic [DATA_W-1:0] b_data,
  input  logic              c_valid,
  input  logic [DATA_W-1:0] c_data,
  input  logic              dma_ack,
  output logic [WORD_W-1:0] pack_word,
  output logic              dma_req,
  output logic              overrun
);
  logic [MODE_W-1:0]                 mode_q;
  logic                              mode_chg;
  logic [RPK_NSRC-1:0]               vld;
  logic [RPK_NSRC-1:0][DATA_W-1:0]   dat;
  logic [RPK_NSRC-1:0]               take_vec;
  logic                              take;
  logic [DATA_W-1:0]                 take_data;
  logic [RPK_SRC_W-1:0]              src_q;
  logic                              slot_q;
  logic                              pair_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= '0;
    else        mode_q <= dma_mode;
  end

  assign mode_chg = (dma_mode != mode_q);
  assign vld = {c_valid, b_valid, a_valid};
  assign dat = {c_data, b_data, a_data};

  rpk_src_sel #(.DATA_W(DATA_W), .NSRC(RPK_NSRC)) u_sel (
    .vld(vld), .dat(dat), .cur_src(src_q), .enable(!mode_chg),
    .take_vec(take_vec), .take(take), .take_data(take_data)
  );

  rpk_pair_builder #(.DATA_W(DATA_W)) u_pair (
    .clk(clk), .rst_n(rst_n), .restart(mode_chg), .take(take),
    .take_data(take_data), .src_q(src_q), .slot_q(slot_q),
    .pair_done(pair_done), .word_q(pack_word)
  );

  rpk_req_ctrl u_req (
    .clk(clk), .rst_n(rst_n), .pair_done(pair_done),
    .req_en(dma_mode == REQ_MODE), .ack(dma_ack),
    .req(dma_req), .ovr(overrun)
  );
endmodule

// File: rtl/rpk_checker.sv
module rpk_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [1:0]  dma_mode,
  input logic        dma_ack,
  input logic [31:0] pack_word,
  input logic        dma_req,
  input logic        overrun,
  input logic        pair_done,
  input logic [2:0]  take_vec,
  input logic        mode_chg,
  input logic [1:0]  src_q,
  input logic        slot_q
);
  a_r1_one_take: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take_vec));
  a_r4_word_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !pair_done |=> $stable(pack_word));
  a_r5_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && dma_mode == 2'b10) |=> dma_req);
  a_r6_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && !dma_ack) |=> dma_req);
  a_r6_req_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_req && dma_ack && !pair_done) |=> !dma_req);
  a_r7_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_done && dma_mode == 2'b10 && dma_req && !dma_ack) |=> overrun);
  a_r7_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  a_r8_no_req_other_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req && dma_mode != 2'b10) |=> !dma_req);
  a_r10_restart: assert property (@(posedge clk) disable iff (!rst_n)
    mode_chg |=> (src_q == 2'd0 && !slot_q));
endmodule

bind rotating_packer rpk_checker u_chk (
  .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode), .dma_ack(dma_ack),
  .pack_word(pack_word), .dma_req(dma_req), .overrun(overrun),
  .pair_done(pair_done), .take_vec(take_vec), .mode_chg(mode_chg),
  .src_q(src_q), .slot_q(slot_q)
);

// File: tb/rotating_packer_tb.sv
module rotating_packer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  dma_mode = 2'b10;
  logic        a_valid = 0, b_valid = 0, c_valid = 0, dma_ack = 0;
  logic [15:0] a_data = 0, b_data = 0, c_data = 0;
  logic [31:0] pack_word;
  logic        dma_req, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // reference model state
  int          m_src = 0;
  int          m_slot = 0;
  logic [15:0] m_low = 0;
  logic [31:0] m_word = 0;
  bit          m_req = 0, m_ovr = 0;
  logic [1:0]  m_mode = 0;

  always #10 clk = ~clk;

  rotating_packer u_dut (
    .clk(clk), .rst_n(rst_n), .dma_mode(dma_mode),
    .a_valid(a_valid), .a_data(a_data), .b_valid(b_valid), .b_data(b_data),
    .c_valid(c_valid), .c_data(c_data), .dma_ack(dma_ack),
    .pack_word(pack_word), .dma_req(dma_req), .overrun(overrun)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_src = 0; m_slot = 0; m_low = 0; m_word = 0;
      m_req = 0; m_ovr = 0; m_mode = 0;
    end else begin
      bit          got;
      bit          paired;
      logic [15:0] d;
      paired = 0;
      got = 0;
      d = 0;
      if (dma_mode != m_mode) begin
        m_src = 0; m_slot = 0;
      end else begin
        case (m_src)
          0: begin got = a_valid; d = a_data; end
          1: begin got = b_valid; d = b_data; end
          default: begin got = c_valid; d = c_data; end
        endcase
        if (got) begin
          if (m_slot == 0) begin m_low = d; m_slot = 1; end
          else begin m_word = {d, m_low}; m_slot = 0; paired = 1; end
          m_src = (m_src + 1) % 3;
        end
      end
      m_mode = dma_mode;
      if (paired && dma_mode == 2'b10) begin
        if (m_req && !dma_ack) m_ovr = 1;
        m_req = 1;
      end else if (dma_ack) m_req = 0;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check("R2/R3/R4 word", pack_word, m_word);
      check("R5/R6/R8 req", {31'd0, dma_req}, {31'd0, m_req});
      check("R7 overrun", {31'd0, overrun}, {31'd0, m_ovr});
    end
  end

  task automatic step(input bit va, input bit vb, input bit vc, input bit ack,
                      input logic [15:0] da, input logic [15:0] db, input logic [15:0] dc);
    a_valid = va; b_valid = vb; c_valid = vc; dma_ack = ack;
    a_data = da; b_data = db; c_data = dc;
    @(posedge clk);
    @(negedge clk);
    a_valid = 0; b_valid = 0; c_valid = 0; dma_ack = 0;
  endtask

  task automatic idle();
    step(0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset word", pack_word, 32'h0);
    check("R9 reset req", {31'd0, dma_req}, 32'h0);
    check("R9 reset overrun", {31'd0, overrun}, 32'h0);
    rst_n = 1;
    idle();                          // mode 10 differs from reset value: restart
    // R1: wrong sources ignored while A is expected
    step(0, 1, 1, 0, 16'h0, 16'hDEAD, 16'hBEEF);
    check("R1 ignored word", pack_word, 32'h0);
    // R3/R2 sequence
    step(1, 0, 0, 0, 16'hA001, 0, 0);
    step(0, 1, 0, 0, 0, 16'hB001, 0);
    check("R3 first word", pack_word, 32'hB001A001);
    check("R5 req raised", {31'd0, dma_req}, 32'h1);
    step(0, 0, 0, 1, 0, 0, 0);
    check("R6 ack clears", {31'd0, dma_req}, 32'h0);
    step(0, 0, 1, 0, 0, 0, 16'hC001);
    step(1, 0, 0, 0, 16'hA002, 0, 0);
    check("R3 second word", pack_word, 32'hA002C001);
    idle();
    check("R6 req held", {31'd0, dma_req}, 32'h1);
    step(0, 1, 0, 1, 0, 16'hB002, 0);
    // R6: pair completes with ack in same cycle
    step(0, 0, 1, 1, 0, 0, 16'hC002);
    check("R3 third word", pack_word, 32'hC002B002);
    check("R6 ack with pair keeps req", {31'd0, dma_req}, 32'h1);
    check("R7 no overrun on ack", {31'd0, overrun}, 32'h0);
    // R7: pair while pending, no ack
    step(1, 1, 1, 0, 16'hA003, 16'hB003, 16'hC003);
    step(1, 1, 1, 0, 16'hA004, 16'hB004, 16'hC004);
    check("R3 fourth word", pack_word, 32'hB004A003);
    check("R7 overrun set", {31'd0, overrun}, 32'h1);
    step(0, 0, 0, 1, 0, 0, 0);
    // R8: other mode, word updates, no request
    dma_mode = 2'b00;
    idle();                          // restart
    step(1, 0, 0, 0, 16'hA005, 0, 0);
    step(0, 1, 0, 0, 0, 16'hB005, 0);
    check("R8 word updates", pack_word, 32'hB005A005);
    check("R8 no req", {31'd0, dma_req}, 32'h0);
    // R10: change mode mid-pair, input that cycle ignored
    step(1, 0, 0, 0, 16'hA006, 0, 0);
    dma_mode = 2'b10;
    step(0, 1, 0, 0, 0, 16'hB006, 0);
    check("R10 change ignores input", pack_word, 32'hB005A005);
    step(1, 0, 0, 0, 16'hA007, 0, 0);
    step(0, 1, 0, 0, 0, 16'hB007, 0);
    check("R10 restart at A low", pack_word, 32'hB007A007);
    step(0, 0, 0, 1, 0, 0, 0);
    // pseudo-random traffic
    lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (i % 97 == 50) dma_mode = lfsr[1:0];
      if (i % 97 == 60) dma_mode = 2'b10;
      step(lfsr[0], lfsr[3], lfsr[7], lfsr[5] & lfsr[9],
           lfsr, ~lfsr, lfsr ^ 16'h5A5A);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule